// File: doc/BRIEF.md
# Synchronous Slave Serial Transmitter

This block sends 8-bit or 9-bit words out on a single data line, one bit per cycle of a shift clock that an external master drives. The shift clock arrives asynchronously. It is brought into the system clock domain through a two-stage synchroniser, and its falling edges are detected there. On each detected falling edge the block places the next bit on the line, so the master can sample it on the following rising edge.

The block holds two words at most. Software writes into a holding register. When the shift register is idle, the word moves into it on the next system clock. A buffer-empty flag tells software when the holding register can take another word. When enabled, the same flag raises an interrupt request. A second word written while the first is still shifting stays in the holding register until the shift register has put its last bit on the line. A write into a full holding register is dropped, and a sticky overrun flag records the loss.

Top module: `sync_slave_tx`

## Requirements
- R1: The transmitter is active only when sync_en=1, port_en=1, clk_src_master=0, rx_cont_en=0, rx_single_en=0 and tx_en=1. While it is inactive, writes are ignored, both registers are emptied (a pending or shifting word is lost), data_out is 1, buf_empty is 1 and overrun is 0.
- R2: A write that finds both registers empty moves to the shift register on the next system clock. buf_empty reads 0 after the write edge and 1 after the following edge.
- R3: A word written while the shift register is busy waits in the holding register. buf_empty stays 0 until the shift register has driven its last bit. The word is moved one system clock later, and buf_empty then reads 1.
- R4: Bits leave least-significant first, bit 0 through bit 7. Each one appears on data_out on the third system clock edge after ext_clk falls. data_out changes at no other time while the block is active.
- R5: If nine_bit_en=1 at the write, the value of bit9_in at that write is sent as a ninth bit after bit 7. Later changes to bit9_in do not affect it.
- R6: irq equals buf_empty AND tx_irq_en.
- R7: A write while the holding register is full is ignored and leaves the pending word unchanged. It sets overrun, which stays 1 until the transmitter becomes inactive.
- R8: A falling edge after the last bit, with no word loaded, drives data_out to 1. A word that was waiting starts with its bit 0 on that same falling edge, with no gap between words.
- R9: One falling edge of ext_clk advances exactly one bit, however long ext_clk stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | Shift clock from the external master |
| sync_en | input | 1 | Synchronous mode enable |
| port_en | input | 1 | Serial port enable |
| clk_src_master | input | 1 | Clock source select; 0 selects slave |
| rx_cont_en | input | 1 | Continuous receive enable; must be 0 |
| rx_single_en | input | 1 | Single receive enable; must be 0 |
| tx_en | input | 1 | Transmit enable |
| nine_bit_en | input | 1 | 9-bit frame select, sampled at write |
| bit9_in | input | 1 | Ninth data bit, sampled at write |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Data word to write |
| tx_irq_en | input | 1 | Interrupt enable |
| data_out | output | 1 | Serial data line |
| buf_empty | output | 1 | Holding register empty |
| irq | output | 1 | Interrupt request |
| overrun | output | 1 | Sticky lost-write flag |

## Verification
Each result has a fixed delay. buf_empty and overrun are due one edge after the write edge. A handoff into an idle shift register is due one edge after that. A data bit is due on the third edge after ext_clk falls, and a handoff that follows the last bit is due on the fourth. The bench drives every input on the falling system clock edge. After each ext_clk transition it waits four system clock edges before sampling. It samples buf_empty at the first and second edges after a write. This places every check exactly where each result is due, and never ahead of it.

// File: rtl/sst_pkg.sv
package sst_pkg;

  function automatic logic tx_allowed(input logic sync_en, input logic port_en,
                                      input logic src_master, input logic rx_cont,
                                      input logic rx_single, input logic tx_en);
    return sync_en & port_en & ~src_master & ~rx_cont & ~rx_single & tx_en;
  endfunction

  function automatic int frame_len(input logic nine, input int data_w);
    return nine ? data_w + 1 : data_w;
  endfunction

endpackage

// File: rtl/sst_clk_edge.sv
module sst_clk_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  output logic fall_evt
);
  logic [SYNC_STAGES:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '1;
    else        stg_q <= {stg_q[SYNC_STAGES-1:0], ext_clk};
  end

  assign fall_evt = stg_q[SYNC_STAGES] & ~stg_q[SYNC_STAGES-1];

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !fall_evt);
endmodule

// File: rtl/sst_hold.sv
module sst_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              nine_en,
  input  logic              bit9_in,
  input  logic              sh_idle,
  output logic              take,
  output logic [DATA_W:0]   hold_word,
  output logic              hold_nine,
  output logic              hold_full,
  output logic              overrun
);
  logic accept, lost;

  assign accept = active & wr_en & ~hold_full;
  assign lost   = active & wr_en &  hold_full;
  assign take   = active & hold_full & sh_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_word <= '0;
      hold_nine <= 1'b0;
      hold_full <= 1'b0;
      overrun   <= 1'b0;
    end else if (!active) begin
      hold_word <= '0;
      hold_nine <= 1'b0;
      hold_full <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (accept) begin
        hold_word <= {nine_en & bit9_in, wr_data};
        hold_nine <= nine_en;
        hold_full <= 1'b1;
      end else if (take) begin
        hold_full <= 1'b0;
      end
      if (lost) overrun <= 1'b1;
    end
  end

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && $past(overrun)) |-> overrun);
  assert_cleared_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!hold_full && !overrun));
  assert_word_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && active && !take) |=> $stable(hold_word));
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter #(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            load,
  input  logic [DATA_W:0] load_word,
  input  logic            load_nine,
  input  logic            fall_evt,
  output logic            data_out,
  output logic            idle
);
  import sst_pkg::*;
  localparam int CNT_W = $clog2(DATA_W + 2);

  logic [DATA_W:0]  sh_q, sh_src;
  logic [CNT_W-1:0] rem_q, rem_src;

  always_comb begin
    sh_src  = load ? load_word : sh_q;
    rem_src = load ? CNT_W'(frame_len(load_nine, DATA_W)) : rem_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; rem_q <= '0; data_out <= 1'b1;
    end else if (!active) begin
      sh_q <= '0; rem_q <= '0; data_out <= 1'b1;
    end else if (fall_evt && rem_src != '0) begin
      data_out <= sh_src[0];
      sh_q     <= sh_src >> 1;
      rem_q    <= rem_src - 1'b1;
    end else if (fall_evt) begin
      data_out <= 1'b1;
      sh_q     <= sh_src;
      rem_q    <= rem_src;
    end else begin
      sh_q  <= sh_src;
      rem_q <= rem_src;
    end
  end

  assign idle = (rem_q == '0);

  assert_line_idle_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> data_out);
  assert_stable_no_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active) && active && !$past(fall_evt)) |-> $stable(data_out));
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= CNT_W'(DATA_W + 1));
  assert_load_on_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> idle);
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk,
  input  logic              sync_en,
  input  logic              port_en,
  input  logic              clk_src_master,
  input  logic              rx_cont_en,
  input  logic              rx_single_en,
  input  logic              tx_en,
  input  logic              nine_bit_en,
  input  logic              bit9_in,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_irq_en,
  output logic              data_out,
  output logic              buf_empty,
  output logic              irq,
  output logic              overrun
);
  import sst_pkg::*;

  logic            active, fall_evt, take, sh_idle, hold_full, hold_nine;
  logic [DATA_W:0] hold_word;

  assign active = tx_allowed(sync_en, port_en, clk_src_master,
                             rx_cont_en, rx_single_en, tx_en);

  sst_clk_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .fall_evt(fall_evt));

  sst_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .active(active), .wr_en(wr_en), .wr_data(wr_data),
    .nine_en(nine_bit_en), .bit9_in(bit9_in), .sh_idle(sh_idle), .take(take),
    .hold_word(hold_word), .hold_nine(hold_nine), .hold_full(hold_full),
    .overrun(overrun));

  sst_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .active(active), .load(take), .load_word(hold_word),
    .load_nine(hold_nine), .fall_evt(fall_evt), .data_out(data_out), .idle(sh_idle));

  assign buf_empty = ~hold_full;
  assign irq       = buf_empty & tx_irq_en;

  assert_empty_after_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> buf_empty);
  assert_no_irq_when_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_irq_en |-> !irq);
endmodule

// File: tb/test_sync_slave_tx.sv
module test_sync_slave_tx;
  logic clk = 0, rst_n = 0, ext_clk = 1;
  logic sync_en = 1, port_en = 1, clk_src_master = 0, rx_cont_en = 0, rx_single_en = 0;
  logic tx_en = 1, nine_bit_en = 0, bit9_in = 0, wr_en = 0, tx_irq_en = 0;
  logic [7:0] wr_data = '0;
  logic data_out, buf_empty, irq, overrun;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sync_slave_tx i_sync_slave_tx (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .sync_en(sync_en), .port_en(port_en),
    .clk_src_master(clk_src_master), .rx_cont_en(rx_cont_en), .rx_single_en(rx_single_en),
    .tx_en(tx_en), .nine_bit_en(nine_bit_en), .bit9_in(bit9_in), .wr_en(wr_en),
    .wr_data(wr_data), .tx_irq_en(tx_irq_en), .data_out(data_out), .buf_empty(buf_empty),
    .irq(irq), .overrun(overrun));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fall(input int low_extra = 0);
    @(negedge clk) ext_clk = 0;
    repeat (4 + low_extra) @(negedge clk);
  endtask

  task automatic rise();
    @(negedge clk) ext_clk = 1;
    repeat (4) @(negedge clk);
  endtask

  // drive a write; returns at the negedge just after the write edge
  task automatic write(input logic [7:0] d, input logic b9);
    @(negedge clk) begin wr_en = 1; wr_data = d; bit9_in = b9; end
    @(negedge clk) wr_en = 0;
  endtask

  task automatic shift_check(input logic [8:0] w, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      fall();
      check(data_out === w[i], req, $sformatf("bit %0d", i), data_out, w[i]);
      rise();
    end
  endtask

  task automatic t_reset();
    check(data_out === 1, "R1", "reset data_out", data_out, 1);
    check(buf_empty === 1, "R1", "reset buf_empty", buf_empty, 1);
    check(overrun === 0, "R1", "reset overrun", overrun, 0);
    check(irq === 0, "R6", "reset irq masked", irq, 0);
  endtask

  task automatic t_single();
    write(8'hA5, 0);
    check(buf_empty === 0, "R2", "empty after write edge", buf_empty, 0);
    @(negedge clk);
    check(buf_empty === 1, "R2", "empty after handoff", buf_empty, 1);
    check(data_out === 1, "R4", "line unchanged before fall", data_out, 1);
    // R9: long low phase advances one bit only
    fall(20);
    check(data_out === 1, "R9", "bit 0 after long low", data_out, 1);
    rise();
    shift_check(9'h052, 7, "R4");
    fall();
    check(data_out === 1, "R8", "idle after last bit", data_out, 1);
    rise();
  endtask

  task automatic t_double();
    write(8'h3C, 0);
    @(negedge clk);
    write(8'hC3, 0);
    check(buf_empty === 0, "R3", "empty low with pending", buf_empty, 0);
    shift_check(9'h03C, 7, "R4");
    check(buf_empty === 0, "R3", "empty still low before last bit", buf_empty, 0);
    fall();
    check(data_out === 0, "R4", "bit 7", data_out, 0);
    check(buf_empty === 1, "R3", "empty after second handoff", buf_empty, 1);
    rise();
    shift_check(9'h0C3, 8, "R8");
    fall();
    check(data_out === 1, "R8", "idle after second word", data_out, 1);
    rise();
  endtask

  task automatic t_nine();
    nine_bit_en = 1;
    write(8'h00, 1);
    bit9_in = 0;
    @(negedge clk);
    shift_check(9'h100, 9, "R5");
    write(8'hFF, 0);
    bit9_in = 1;
    @(negedge clk);
    shift_check(9'h0FF, 9, "R5");
    fall();
    check(data_out === 1, "R5", "idle after ninth bit", data_out, 1);
    rise();
    nine_bit_en = 0;
  endtask

  task automatic t_overrun();
    write(8'h0F, 0);
    @(negedge clk);
    write(8'h55, 0);
    check(overrun === 0, "R7", "no overrun yet", overrun, 0);
    write(8'hAA, 0);
    check(overrun === 1, "R7", "overrun set", overrun, 1);
    shift_check(9'h00F, 8, "R7");
    shift_check(9'h055, 8, "R7");
    check(overrun === 1, "R7", "overrun sticky", overrun, 1);
    @(negedge clk) tx_en = 0;
    @(negedge clk);
    check(overrun === 0, "R1", "overrun cleared when off", overrun, 0);
    tx_en = 1;
    fall();
    check(data_out === 1, "R8", "idle after overrun test", data_out, 1);
    rise();
  endtask

  task automatic t_irq();
    tx_irq_en = 1;
    @(negedge clk);
    check(irq === 1, "R6", "irq while empty", irq, 1);
    write(8'h81, 0);
    @(negedge clk);
    write(8'h18, 0);
    check(irq === 0, "R6", "irq low while full", irq, 0);
    tx_irq_en = 0;
    @(negedge clk);
    tx_en = 0;
    @(negedge clk);
    check(buf_empty === 1, "R1", "empty when disabled", buf_empty, 1);
    tx_en = 1;
  endtask

  task automatic t_enable();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk) case (k)
        0: sync_en = 0;
        1: port_en = 0;
        2: clk_src_master = 1;
        3: rx_cont_en = 1;
        4: rx_single_en = 1;
        default: tx_en = 0;
      endcase
      write(8'h00, 0);
      @(negedge clk);
      check(buf_empty === 1, "R1", $sformatf("write ignored cfg %0d", k), buf_empty, 1);
      fall();
      check(data_out === 1, "R1", $sformatf("line high cfg %0d", k), data_out, 1);
      rise();
      sync_en = 1; port_en = 1; clk_src_master = 0;
      rx_cont_en = 0; rx_single_en = 0; tx_en = 1;
      fall();
      check(data_out === 1, "R1", $sformatf("nothing queued cfg %0d", k), data_out, 1);
      rise();
    end
    // disable mid-word
    write(8'h00, 0);
    @(negedge clk);
    shift_check(9'h000, 2, "R4");
    @(negedge clk) tx_en = 0;
    @(negedge clk);
    check(data_out === 1, "R1", "line high after mid-word off", data_out, 1);
    tx_en = 1;
    fall();
    check(data_out === 1, "R1", "shifted word dropped", data_out, 1);
    rise();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_double();
    t_nine();
    t_overrun();
    t_irq();
    t_enable();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule